// File: doc/BRIEF.md
# Recursive Rotation Sine/Cosine Oscillator

The block produces one sine and one cosine sample each time its sample enable is high. It keeps no phase accumulator and no lookup table. It holds the current point on the unit circle as a fixed-point pair and turns that point by a fixed angle step on each enabled sample. The rotation uses two wide coefficients, the cosine and the sine of the step angle. The step angle is 2·π·f/fs. An outside agent computes the coefficients and hands them to the block. Because the coefficients are wide, a change of a single hertz at a sample rate near a gigasample per second still reaches a bit of the coefficient. That gives the block a far finer frequency grid than a table-based generator of similar cost.

A start pulse resets the point to angle zero (sine 0, cosine 1) and latches a coefficient pair in the same edge. A separate load pulse swaps in a new coefficient pair while running, and the phase carries on from where it was. Each enabled sample emits the current point, marked by a one-cycle valid flag, and then advances the point.

Top module: `rot_osc`

## Requirements
- R1: While reset is held, `sin_out` and `cos_out` are 0 and `out_valid` is low.
- R2: A `start` pulse sets the internal point to sine 0 and cosine 1.0 and latches `coef_cos` and `coef_sin`. In the fixed-point format 1.0 is the code 2^38. `start` has priority over `sample_en` in the same cycle, so no sample is produced and the point is not advanced in that cycle. The first valid sample after `start` is (0, 1.0).
- R3: Each enabled sample advances the point (s, c) to (s·K + c·J, c·K − s·J). Both values are computed from the same old point and stored at the same edge. K is the latched cosine coefficient and J is the latched sine coefficient.
- R4: All samples and coefficients are signed W-bit fixed point with W−2 fraction bits: 2 integer bits, range −2 to just under +2, value = code / 2^(W−2), and W = 40 by default. Each sum of products is rounded to the nearest code before it is stored.
- R5: After every clock edge with `sample_en` high and `start` low, `out_valid` is high for the following cycle. `sin_out`/`cos_out` then carry the point as it was before that step. After any other edge `out_valid` is low.
- R6: When neither `sample_en` nor `start` is high, `sin_out` and `cos_out` keep their values at the next edge.
- R7: A `coef_load` pulse latches a new coefficient pair without touching the phase. The new pair is used from the next enabled sample after the load edge. A step taken in the same edge as the load still uses the old pair.
- R8: Over 10,000 consecutive samples each output stays within 1e-6 of the ideal sin/cos of the accumulated phase. The amplitude error |s²+c²−1| stays below 1e-6.
- R9: With a step angle of 2π/10 (100 MHz tone at 1 GSps), the first five valid samples are sine 0, 0.5878, 0.9511, 0.9511, 0.5878 and cosine 1, 0.8090, 0.3090, −0.3090, −0.8090, each within 1e-4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Reset phase to zero and latch coefficients |
| coef_load | input | 1 | Latch new coefficients, keep phase |
| coef_cos | input | W | Cosine of step angle, signed fixed point |
| coef_sin | input | W | Sine of step angle, signed fixed point |
| sample_en | input | 1 | Produce a sample and advance the point |
| sin_out | output | W | Sine sample, signed fixed point |
| cos_out | output | W | Cosine sample, signed fixed point |
| out_valid | output | 1 | Sample on sin_out/cos_out is new this cycle |

## Verification
The exact tenth-of-a-turn sequence checks the sign conventions of both recurrence terms. A swapped or negated term breaks the third sample at once. A long run at an irregular frequency with an unbroken enable shows whether rounding error grows into phase or amplitude drift over 10,000 steps. A gappy enable pattern separates stepping from holding. A load issued between samples, another issued in the same cycle as a step, and a start issued together with a step show whether the phase stays continuous across a coefficient change and whether start takes priority.

// File: rtl/rot_osc_pkg.sv
`timescale 1ns/1ps
package rot_osc_pkg;
  // default sample/coefficient width; two of these bits are integer bits
  parameter int unsigned DEF_W = 40;

  // what the point register does on a given edge
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_START = 2'd1,
    UPD_STEP  = 2'd2
  } upd_e;
endpackage

// File: rtl/rot_osc_coef.sv
`timescale 1ns/1ps
// Holds the rotation coefficient pair; reset value is a zero-angle step.
module rot_osc_coef #(
  parameter int unsigned W = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic signed [W-1:0] cos_in,
  input  logic signed [W-1:0] sin_in,
  output logic signed [W-1:0] cos_q,
  output logic signed [W-1:0] sin_q
);
  localparam int unsigned F = W - 2;
  localparam logic signed [W-1:0] ONE = W'(1) << F;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_q <= ONE;
      sin_q <= '0;
    end else if (ld) begin
      cos_q <= cos_in;
      sin_q <= sin_in;
    end
  end
endmodule

// File: rtl/rot_osc_rot.sv
`timescale 1ns/1ps
// Combinational rotation of the point by the step angle.
module rot_osc_rot #(
  parameter int unsigned W = 40
) (
  input  logic signed [W-1:0] s,
  input  logic signed [W-1:0] c,
  input  logic signed [W-1:0] kc,
  input  logic signed [W-1:0] ks,
  output logic signed [W-1:0] s_nx,
  output logic signed [W-1:0] c_nx
);
  localparam int unsigned F  = W - 2;
  localparam int unsigned AW = 2 * W + 1;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (F - 1);

  // (a*b + sg*c*d) rounded to nearest, rescaled to W bits
  function automatic logic signed [W-1:0] rnd_dot(
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] b,
    input logic signed [W-1:0] x,
    input logic signed [W-1:0] y,
    input logic                neg
  );
    logic signed [AW-1:0] pa, pb, acc, sh;
    pa  = AW'(a) * AW'(b);
    pb  = AW'(x) * AW'(y);
    acc = neg ? (pa - pb + HALF) : (pa + pb + HALF);
    sh  = acc >>> F;
    return sh[W-1:0];
  endfunction

  assign s_nx = rnd_dot(s, kc, c, ks, 1'b0);
  assign c_nx = rnd_dot(c, kc, s, ks, 1'b1);
endmodule

// File: rtl/rot_osc.sv
`timescale 1ns/1ps
module rot_osc #(
  parameter int unsigned W = rot_osc_pkg::DEF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                coef_load,
  input  logic signed [W-1:0] coef_cos,
  input  logic signed [W-1:0] coef_sin,
  input  logic                sample_en,
  output logic signed [W-1:0] sin_out,
  output logic signed [W-1:0] cos_out,
  output logic                out_valid
);
  import rot_osc_pkg::*;

  localparam int unsigned F = W - 2;
  localparam logic signed [W-1:0] ONE = W'(1) << F;

  // named internal wires, observed by the bound checker
  logic signed [W-1:0] k_cos, k_sin;
  logic signed [W-1:0] st_sin, st_cos;
  logic signed [W-1:0] nx_sin, nx_cos;
  upd_e                upd;

  assign upd = start     ? UPD_START :
               sample_en ? UPD_STEP  : UPD_HOLD;

  rot_osc_coef #(.W(W)) u_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (start | coef_load),
    .cos_in (coef_cos),
    .sin_in (coef_sin),
    .cos_q  (k_cos),
    .sin_q  (k_sin)
  );

  rot_osc_rot #(.W(W)) u_rot (
    .s    (st_sin),
    .c    (st_cos),
    .kc   (k_cos),
    .ks   (k_sin),
    .s_nx (nx_sin),
    .c_nx (nx_cos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sin    <= '0;
      st_cos    <= ONE;
      sin_out   <= '0;
      cos_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      unique case (upd)
        UPD_START: begin
          st_sin    <= '0;
          st_cos    <= ONE;
          out_valid <= 1'b0;
        end
        UPD_STEP: begin
          sin_out   <= st_sin;
          cos_out   <= st_cos;
          st_sin    <= nx_sin;
          st_cos    <= nx_cos;
          out_valid <= 1'b1;
        end
        default: out_valid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rot_osc_chk.sv
`timescale 1ns/1ps
module rot_osc_chk #(
  parameter int unsigned W = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                coef_load,
  input logic signed [W-1:0] coef_cos,
  input logic signed [W-1:0] coef_sin,
  input logic                sample_en,
  input logic signed [W-1:0] sin_out,
  input logic signed [W-1:0] cos_out,
  input logic                out_valid,
  input logic signed [W-1:0] st_sin,
  input logic signed [W-1:0] st_cos,
  input logic signed [W-1:0] k_cos,
  input logic signed [W-1:0] k_sin
);
  localparam logic signed [W-1:0] ONE = W'(1) << (W - 2);

  p_start_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st_sin == '0) && (st_cos == ONE));

  p_valid_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !start) |=> out_valid);

  p_no_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start || !sample_en) |=> !out_valid);

  p_out_prev_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !start) |=> (sin_out == $past(st_sin)) && (cos_out == $past(st_cos)));

  p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !start) |=> $stable(sin_out) && $stable(cos_out));

  p_coef_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start || coef_load) |=> (k_cos == $past(coef_cos)) && (k_sin == $past(coef_sin)));

  p_load_keeps_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_load && !start && !sample_en) |=> $stable(st_sin) && $stable(st_cos));
endmodule

bind rot_osc rot_osc_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .coef_load (coef_load),
  .coef_cos  (coef_cos),
  .coef_sin  (coef_sin),
  .sample_en (sample_en),
  .sin_out   (sin_out),
  .cos_out   (cos_out),
  .out_valid (out_valid),
  .st_sin    (st_sin),
  .st_cos    (st_cos),
  .k_cos     (k_cos),
  .k_sin     (k_sin)
);

// File: tb/rot_osc_test.sv
`timescale 1ns/1ps
module rot_osc_test;
  localparam int W = 40;
  localparam real SCALE = 274877906944.0; // 2^38
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, coef_load = 1'b0, sample_en = 1'b0;
  logic signed [W-1:0] coef_cos = '0, coef_sin = '0;
  logic signed [W-1:0] sin_out, cos_out;
  logic out_valid;

  always #10 clk = ~clk; // 50 MHz

  rot_osc #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .coef_load(coef_load),
    .coef_cos(coef_cos), .coef_sin(coef_sin), .sample_en(sample_en),
    .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
  );

  // scoreboard
  real   q_s[$], q_c[$], q_t[$];
  string q_r[$];
  int    errs = 0, checks = 0;
  real   ph = 0.0, dx_act = 0.0;
  real   last_s = 0.0, last_c = 0.0;
  bit    done = 1'b0;

  function automatic real to_r(input logic signed [W-1:0] v);
    longint t;
    t = longint'(v);
    return real'(t) / SCALE;
  endfunction

  function automatic logic signed [W-1:0] to_fx(input real x);
    longint t;
    t = longint'(x * SCALE);
    return t[W-1:0];
  endfunction

  function automatic real fabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic chk(input string req, input string what, input real act,
                     input real exp, input real tol);
    checks++;
    if (fabs(act - exp) > tol) begin
      errs++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic act,
                         input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare whenever a sample is flagged
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (q_s.size() == 0) begin
        chk_bit("R5", "unexpected valid", 1'b1, 1'b0);
      end else begin
        real es, ec, et;
        string rq;
        es = q_s.pop_front(); ec = q_c.pop_front();
        et = q_t.pop_front(); rq = q_r.pop_front();
        last_s = to_r(sin_out); last_c = to_r(cos_out);
        chk(rq, "sin", last_s, es, et);
        chk(rq, "cos", last_c, ec, et);
      end
    end
  end

  // driver: program step angle; with_start resets phase (R2), else R7
  task automatic set_step(input real dxv, input bit with_start, input bit with_step,
                          input string rq);
    @(negedge clk);
    coef_cos = to_fx($cos(dxv));
    coef_sin = to_fx($sin(dxv));
    if (with_start) start = 1'b1; else coef_load = 1'b1;
    sample_en = with_step;
    if (with_step && !with_start) begin
      // same-edge step still uses the old pair (R7)
      q_s.push_back($sin(ph)); q_c.push_back($cos(ph));
      q_t.push_back(1e-6); q_r.push_back(rq);
      ph = ph + dx_act;
    end
    if (with_start) ph = 0.0;
    dx_act = dxv;
    @(negedge clk);
    start = 1'b0; coef_load = 1'b0; sample_en = 1'b0;
  endtask

  // gap=0: continuous enable; otherwise idle cycles between steps
  task automatic run(input int n, input int gap, input string rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_en = 1'b1;
      q_s.push_back($sin(ph)); q_c.push_back($cos(ph));
      q_t.push_back(1e-6); q_r.push_back(rq);
      ph = ph + dx_act;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        sample_en = 1'b0;
      end
    end
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    real r9s[5], r9c[5];
    logic signed [W-1:0] hs, hc;
    r9s = '{0.0, 0.5878, 0.9511, 0.9511, 0.5878};
    r9c = '{1.0, 0.8090, 0.3090, -0.3090, -0.8090};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "sin_out", to_r(sin_out), 0.0, 0.0);
    chk("R1", "cos_out", to_r(cos_out), 0.0, 0.0);
    chk_bit("R1", "out_valid", out_valid, 1'b0);
    rst_n = 1'b1;

    // R9 and R2: tenth-turn step, first sample (0,1), literal values
    set_step(2.0 * PI / 10.0, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      sample_en = 1'b1;
      q_s.push_back(r9s[i]); q_c.push_back(r9c[i]);
      q_t.push_back(1e-4); q_r.push_back(i == 0 ? "R2" : "R9");
      ph = ph + dx_act;
    end
    @(negedge clk);
    sample_en = 1'b0;
    @(negedge clk);

    // R6: hold with no enable
    hs = sin_out; hc = cos_out;
    repeat (4) @(negedge clk);
    chk("R6", "sin held", to_r(sin_out), to_r(hs), 0.0);
    chk("R6", "cos held", to_r(cos_out), to_r(hc), 0.0);
    chk_bit("R5", "valid low while idle", out_valid, 1'b0);

    // R3/R5: gappy enable continues the same tone
    run(40, 2, "R3");

    // R2: start together with sample_en -> no sample, phase reset
    @(negedge clk);
    coef_cos = to_fx($cos(0.37)); coef_sin = to_fx($sin(0.37));
    start = 1'b1; sample_en = 1'b1;
    ph = 0.0; dx_act = 0.37;
    @(negedge clk);
    start = 1'b0; sample_en = 1'b0;
    chk_bit("R2", "no valid after start+en", out_valid, 1'b0);
    run(20, 0, "R2");

    // R8/R4: long continuous run at a fine, irregular frequency
    set_step(2.0 * PI * 12345678.0 / 1.0e9, 1'b1, 1'b0, "R8");
    run(10000, 0, "R8");
    repeat (2) @(negedge clk);
    chk("R8", "amplitude drift", last_s * last_s + last_c * last_c, 1.0, 1e-6);

    // R7: load between samples, phase continues
    set_step(2.0 * PI * 12345679.0 / 1.0e9 * 3.0, 1'b0, 1'b0, "R7");
    run(300, 0, "R7");
    // R7: load in the same edge as a step
    set_step(0.9, 1'b0, 1'b1, "R7");
    run(300, 1, "R7");
    repeat (3) @(negedge clk);
    chk("R7", "queue drained", real'(q_s.size()), 0.0, 0.0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule